// File: doc/BRIEF.md
# DRAM Bank Address Interleaver

This block sits on the miss path between a cache and a multi-bank DRAM controller. Each cycle it may accept one physical address. One cycle later it returns the bank index, the row index and the column (the offset within the row) that the address maps to. A run-time mode input selects the mapping scheme. The schemes are: plain bit-select interleaving at three positions, a bank scramble that folds low cache-tag bits into the bank bits, and an exchange of tag bits with the top column bits. A per-request inverse flag runs the mapping backwards, so a location taken from the controller can be turned back into the address that produced it.

The address width, the cache block offset width, the cache set index width, the bank field width and the column width are all parameters. The scramble source is the lowest group of tag bits that lies clear of the bank field. In the normal case this group starts at the bottom of the tag. When the row buffers together are larger than one cache way, the group starts just above the bank field instead. Parameter sets for which no such group fits, or for which the exchange width cannot be placed, stop elaboration with an error.

Top module: `addr_interleaver`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle with `in_valid` high and is low otherwise. The result outputs are registered and change only after an accepted request.
- R2: Mode code 1 (row-local) takes the bank from address bits [PAGE_W+BANK_W-1:PAGE_W], the column from bits [PAGE_W-1:0] and the row from the bits above the bank. The unused codes 5, 6 and 7 behave like code 1.
- R3: Mode code 0 (line-spread) takes the bank from the BANK_W bits just above the BLK_W-bit block offset. The remaining address bits keep their order and are compacted: the lowest PAGE_W of them form the column and the rest form the row.
- R4: Mode code 2 (top-select) takes the bank from the top BANK_W address bits. The column is bits [PAGE_W-1:0] and the row is the bits between the column and the bank.
- R5: Mode code 3 (scramble) forms each bank bit as the row-local bank bit XOR the matching bit of the scramble source. The column and the row pass through unchanged.
- R6: The scramble source is BANK_W bits starting at the tag base (BLK_W+SET_W). If the bank field reaches into the tag, the source starts at the first bit above the bank field.
- R7: Mode code 4 (exchange) swaps the n lowest scramble-source bits with the n top column bits, then maps as in code 1. n=0 leaves the address unchanged, and any n above SWAP_MAX acts as SWAP_MAX.
- R8: With `in_inverse` high, `in_addr` is taken as a packed location {row, bank, column}, and `out_addr` returns the address that maps to it in the active mode. In every mode the inverse undoes the forward mapping.
- R9: The mode and n are captured only at a clock edge where `in_valid` and `out_valid` were both low. A change made while a request is pending or being returned has no effect on that request.
- R10: In forward operation `out_addr` is the packed location {out_row, out_bank, out_col}. In inverse operation `out_row`, `out_bank` and `out_col` are the fields of the location that was supplied.
- R11: During and after reset `out_valid` is low and every result output is zero. The active mode is code 1 with n=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Mapping mode code (0 line-spread, 1 row-local, 2 top-select, 3 scramble, 4 exchange) |
| cfg_swap_n | input | $clog2(SWAP_MAX+1) | Number of bits exchanged in mode 4 |
| in_valid | input | 1 | Request strobe |
| in_inverse | input | 1 | Run the mapping backwards for this request |
| in_addr | input | ADDR_W | Physical address, or packed location when inverse |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_bank | output | BANK_W | Bank index of the location |
| out_row | output | ADDR_W-BANK_W-PAGE_W | Row index of the location |
| out_col | output | PAGE_W | Column (offset within the row) of the location |
| out_addr | output | ADDR_W | Packed location (forward) or recovered address (inverse) |

## Verification
A new mode can arrive in the same cycle as a request, and a request can arrive while the previous result is still on the outputs. Both cases test whether configuration capture and request processing stay apart. The bench settles the row-local mode and then presents a scramble mode code together with a back-to-back pair of requests. Both results must come out row-local, unscrambled. Only after two quiet cycles may a further request show the scrambled bank.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam logic [2:0] MAP_LINE = 3'd0;
  localparam logic [2:0] MAP_PAGE = 3'd1;
  localparam logic [2:0] MAP_HIGH = 3'd2;
  localparam logic [2:0] MAP_PERM = 3'd3;
  localparam logic [2:0] MAP_SWAP = 3'd4;
endpackage

// File: rtl/ilv_swap.sv
module ilv_swap #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_W   = 11,
  parameter int SRC_LO   = 20,
  parameter int SWAP_MAX = 4,
  parameter int NW       = 3
) (
  input  logic [ADDR_W-1:0] a,
  input  logic [NW-1:0]     n,
  output logic [ADDR_W-1:0] y
);
  logic [NW-1:0] n_eff;
  assign n_eff = (n > NW'(SWAP_MAX)) ? NW'(SWAP_MAX) : n;

  always_comb begin
    y = a;
    for (int i = 0; i < SWAP_MAX; i++) begin
      if (i < int'(n_eff)) begin
        y[PAGE_W - int'(n_eff) + i] = a[SRC_LO + i];
        y[SRC_LO + i]               = a[PAGE_W - int'(n_eff) + i];
      end
    end
  end
endmodule

// File: rtl/ilv_fwd.sv
module ilv_fwd
  import ilv_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BLK_W    = 6,
  parameter int BANK_W   = 3,
  parameter int PAGE_W   = 11,
  parameter int SRC_LO   = 20,
  parameter int SWAP_MAX = 4,
  parameter int NW       = 3
) (
  input  logic [2:0]        mode,
  input  logic [NW-1:0]     swap_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] loc
);
  localparam logic [ADDR_W-1:0] BLK_MASK  = (ADDR_W'(1) << BLK_W) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] COL_MASK  = (ADDR_W'(1) << PAGE_W) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] REST_MASK = (ADDR_W'(1) << (ADDR_W - BANK_W)) - ADDR_W'(1);

  logic [ADDR_W-1:0] swapped, line_rest, high_rest;
  logic [BANK_W-1:0] line_bank, high_bank, src_bits;

  ilv_swap #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SRC_LO(SRC_LO),
             .SWAP_MAX(SWAP_MAX), .NW(NW)) u_swap (
    .a(addr), .n(swap_n), .y(swapped));

  assign line_bank = addr[BLK_W +: BANK_W];
  assign line_rest = ((addr >> (BLK_W + BANK_W)) << BLK_W) | (addr & BLK_MASK);
  assign high_bank = addr[ADDR_W-1 -: BANK_W];
  assign high_rest = addr & REST_MASK;
  assign src_bits  = addr[SRC_LO +: BANK_W];

  function automatic logic [ADDR_W-1:0] pack_loc(input logic [ADDR_W-1:0] rest,
                                                  input logic [BANK_W-1:0] bank);
    return ((rest >> PAGE_W) << (PAGE_W + BANK_W)) |
           (ADDR_W'(bank) << PAGE_W) | (rest & COL_MASK);
  endfunction

  always_comb begin
    case (mode)
      MAP_LINE: loc = pack_loc(line_rest, line_bank);
      MAP_HIGH: loc = pack_loc(high_rest, high_bank);
      MAP_PERM: loc = addr ^ (ADDR_W'(src_bits) << PAGE_W);
      MAP_SWAP: loc = swapped;
      default:  loc = addr;
    endcase
  end
endmodule

// File: rtl/ilv_inv.sv
module ilv_inv
  import ilv_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BLK_W    = 6,
  parameter int BANK_W   = 3,
  parameter int PAGE_W   = 11,
  parameter int SRC_LO   = 20,
  parameter int SWAP_MAX = 4,
  parameter int NW       = 3
) (
  input  logic [2:0]        mode,
  input  logic [NW-1:0]     swap_n,
  input  logic [ADDR_W-1:0] loc,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] BLK_MASK = (ADDR_W'(1) << BLK_W) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] COL_MASK = (ADDR_W'(1) << PAGE_W) - ADDR_W'(1);

  logic [ADDR_W-1:0] unswapped, rest;
  logic [BANK_W-1:0] bank, src_bits;

  ilv_swap #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SRC_LO(SRC_LO),
             .SWAP_MAX(SWAP_MAX), .NW(NW)) u_swap (
    .a(loc), .n(swap_n), .y(unswapped));

  assign bank     = loc[PAGE_W +: BANK_W];
  assign rest     = ((loc >> (PAGE_W + BANK_W)) << PAGE_W) | (loc & COL_MASK);
  assign src_bits = loc[SRC_LO +: BANK_W];

  always_comb begin
    case (mode)
      MAP_LINE: addr = ((rest >> BLK_W) << (BLK_W + BANK_W)) |
                       (ADDR_W'(bank) << BLK_W) | (rest & BLK_MASK);
      MAP_HIGH: addr = rest | (ADDR_W'(bank) << (ADDR_W - BANK_W));
      MAP_PERM: addr = loc ^ (ADDR_W'(src_bits) << PAGE_W);
      MAP_SWAP: addr = unswapped;
      default:  addr = loc;
    endcase
  end
endmodule

// File: rtl/addr_interleaver.sv
module addr_interleaver
  import ilv_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int BLK_W    = 6,
  parameter int SET_W    = 14,
  parameter int BANK_W   = 3,
  parameter int PAGE_W   = 11,
  parameter int SWAP_MAX = 4,
  localparam int NW      = $clog2(SWAP_MAX + 1),
  localparam int ROW_W   = ADDR_W - BANK_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_mode,
  input  logic [NW-1:0]     cfg_swap_n,
  input  logic              in_valid,
  input  logic              in_inverse,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic [PAGE_W-1:0] out_col,
  output logic [ADDR_W-1:0] out_addr
);
  localparam int TAG_LO  = BLK_W + SET_W;
  localparam int BANK_HI = PAGE_W + BANK_W;
  localparam int SRC_LO  = (BANK_HI > TAG_LO) ? BANK_HI : TAG_LO;

  if (SRC_LO + BANK_W > ADDR_W) begin : g_bad_src
    $error("scramble source does not fit above the bank field");
  end
  if (SWAP_MAX > PAGE_W || SRC_LO + SWAP_MAX > ADDR_W) begin : g_bad_swap
    $error("exchange width cannot be placed");
  end
  if (BLK_W + BANK_W > ADDR_W || ROW_W < 1) begin : g_bad_fields
    $error("field widths exceed the address");
  end

  logic [2:0]        mode_q;
  logic [NW-1:0]     swap_n_q;
  logic              inv_q;
  logic [ADDR_W-1:0] fwd_loc, inv_addr, loc_q, addr_q;

  ilv_fwd #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BANK_W(BANK_W), .PAGE_W(PAGE_W),
            .SRC_LO(SRC_LO), .SWAP_MAX(SWAP_MAX), .NW(NW)) u_fwd (
    .mode(mode_q), .swap_n(swap_n_q), .addr(in_addr), .loc(fwd_loc));

  ilv_inv #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BANK_W(BANK_W), .PAGE_W(PAGE_W),
            .SRC_LO(SRC_LO), .SWAP_MAX(SWAP_MAX), .NW(NW)) u_inv (
    .mode(mode_q), .swap_n(swap_n_q), .loc(in_addr), .addr(inv_addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MAP_PAGE;
      swap_n_q <= '0;
    end else if (!in_valid && !out_valid) begin
      mode_q   <= cfg_mode;
      swap_n_q <= cfg_swap_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      inv_q     <= 1'b0;
      loc_q     <= '0;
      addr_q    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        inv_q  <= in_inverse;
        loc_q  <= in_inverse ? in_addr  : fwd_loc;
        addr_q <= in_inverse ? inv_addr : fwd_loc;
      end
    end
  end

  assign out_col  = loc_q[PAGE_W-1:0];
  assign out_bank = loc_q[PAGE_W +: BANK_W];
  assign out_row  = loc_q[ADDR_W-1 -: ROW_W];
  assign out_addr = addr_q;
endmodule

// File: rtl/addr_interleaver_chk.sv
module addr_interleaver_chk
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 11,
  parameter int SRC_LO = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic [PAGE_W-1:0] out_col,
  input logic [BANK_W-1:0] out_bank,
  input logic [ADDR_W-1:0] out_addr,
  input logic [2:0]        mode_q,
  input logic              inv_q
);
  // R1
  lat_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> ($past(!in_valid) && $past(!out_valid)));

  // R2
  col_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !inv_q && (mode_q == MAP_PAGE || mode_q == MAP_PERM || mode_q == MAP_HIGH))
      |-> out_col == $past(in_addr[PAGE_W-1:0]));

  // R5
  perm_xor_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !inv_q && mode_q == MAP_PERM)
      |-> (out_bank ^ out_addr[SRC_LO +: BANK_W]) == $past(in_addr[PAGE_W +: BANK_W]));

  // R8
  page_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && inv_q && mode_q == MAP_PAGE) |-> out_addr == $past(in_addr));
endmodule

bind addr_interleaver addr_interleaver_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .PAGE_W(PAGE_W), .SRC_LO(SRC_LO)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
  .out_valid(out_valid), .out_col(out_col), .out_bank(out_bank),
  .out_addr(out_addr), .mode_q(mode_q), .inv_q(inv_q)
);

// File: tb/sim_addr_interleaver.sv
module sim_addr_interleaver;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_mode = 3'd1;
  logic [2:0]  cfg_swap_n = 3'd0;
  logic        in_valid = 1'b0;
  logic        in_inverse = 1'b0;
  logic [31:0] in_addr = '0;
  logic        out_valid, v1;
  logic [2:0]  out_bank, b1;
  logic [17:0] out_row;
  logic [12:0] r1;
  logic [10:0] out_col;
  logic [15:0] c1;
  logic [31:0] out_addr, a1;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  addr_interleaver u0 (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_swap_n(cfg_swap_n),
    .in_valid(in_valid), .in_inverse(in_inverse), .in_addr(in_addr),
    .out_valid(out_valid), .out_bank(out_bank), .out_row(out_row),
    .out_col(out_col), .out_addr(out_addr));

  // bank field reaches into the tag: bank bits 18:16, tag base 14, source base 19
  addr_interleaver #(.SET_W(8), .PAGE_W(16)) u1 (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_swap_n(cfg_swap_n),
    .in_valid(in_valid), .in_inverse(in_inverse), .in_addr(in_addr),
    .out_valid(v1), .out_bank(b1), .out_row(r1), .out_col(c1), .out_addr(a1));

  typedef struct packed {
    logic [2:0]  mode;
    logic [2:0]  n;
    logic        inv;
    logic [31:0] addr;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 3'd0, 1'b0, 32'h12345678, 32'h12345678},  // R2 row-local
    '{3'd7, 3'd0, 1'b0, 32'h12345678, 32'h12345678},  // R2 unused code
    '{3'd0, 3'd0, 1'b0, 32'h000001C5, 32'h00003805},  // R3 line-spread
    '{3'd0, 3'd0, 1'b0, 32'h00010045, 32'h00010805},  // R3 with row bits
    '{3'd0, 3'd0, 1'b1, 32'h00010805, 32'h00010045},  // R8 line inverse
    '{3'd2, 3'd0, 1'b0, 32'hA0000123, 32'h00002923},  // R4 top-select
    '{3'd2, 3'd0, 1'b1, 32'h00002923, 32'hA0000123},  // R8 top inverse
    '{3'd3, 3'd0, 1'b0, 32'h00601000, 32'h00602000},  // R5 scramble
    '{3'd3, 3'd0, 1'b1, 32'h00602000, 32'h00601000},  // R8 scramble inverse
    '{3'd3, 3'd0, 1'b0, 32'h00601ABC, 32'h00602ABC},  // R5 column kept
    '{3'd4, 3'd2, 1'b0, 32'h00100400, 32'h00200200},  // R7 exchange n=2
    '{3'd4, 3'd2, 1'b1, 32'h00200200, 32'h00100400},  // R8 exchange inverse
    '{3'd4, 3'd0, 1'b0, 32'h00100400, 32'h00100400},  // R7 n=0
    '{3'd4, 3'd7, 1'b0, 32'h00A00000, 32'h00000500}   // R7 n clamps to 4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic [2:0] n);
    @(negedge clk);
    cfg_mode = m;
    cfg_swap_n = n;
    repeat (3) @(negedge clk);
  endtask

  // drive one request; returns at the negedge where the result is visible
  task automatic request(input logic inv, input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1;
    in_inverse = inv;
    in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 valid", 32'(out_valid), 32'd0);
    check("R11 addr", out_addr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 idle after reset", 32'(out_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      set_cfg(VEC[i].mode, VEC[i].n);
      request(VEC[i].inv, VEC[i].addr);
      check("R1 valid", 32'(out_valid), 32'd1);
      check("R2-R8 vector addr", out_addr, VEC[i].exp);
      if (!VEC[i].inv) begin
        // R10 forward fields split the packed location
        check("R10 bank", 32'(out_bank), 32'(VEC[i].exp[13:11]));
        check("R10 col",  32'(out_col),  32'(VEC[i].exp[10:0]));
        check("R10 row",  32'(out_row),  32'(VEC[i].exp[31:14]));
      end else begin
        check("R10 inv bank", 32'(out_bank), 32'(VEC[i].addr[13:11]));
      end
      @(negedge clk);
      check("R1 valid drops", 32'(out_valid), 32'd0);
    end

    // R9: mode change arriving with back-to-back requests is ignored
    set_cfg(3'd1, 3'd0);
    @(negedge clk);
    cfg_mode = 3'd3;
    in_valid = 1'b1;
    in_inverse = 1'b0;
    in_addr = 32'h00601000;
    @(negedge clk);
    check("R9 first", out_addr, 32'h00601000);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second", out_addr, 32'h00601000);
    check("R1 back-to-back", 32'(out_valid), 32'd1);
    repeat (2) @(negedge clk);
    request(1'b0, 32'h00601000);
    check("R9 applied after idle", out_addr, 32'h00602000);

    // R6: overlapping bank field, source taken above bank field
    request(1'b0, 32'h00290000);
    check("R6 overlap fwd", a1, 32'h002C0000);
    check("R6 overlap bank", 32'(b1), 32'd4);
    request(1'b1, 32'h002C0000);
    check("R6 overlap inverse", a1, 32'h00290000);

    // R11: synchronous reset clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R11 reset clears addr", out_addr, 32'd0);
    check("R11 reset clears valid", 32'(out_valid), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule